// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. With paging switched off it returns the linear address unchanged in the next cycle and reads no memory. With paging switched on it walks a two-level table in memory. The first read fetches a directory entry, found from a root base input and the top index field of the address. The second read fetches a table entry, found from the page-table base in that directory entry and the middle index field. The result joins the frame base from the table entry with the low offset bits of the linear address.

Each entry carries three permission bits. The walker checks these bits at both levels against the kind of access, which is a read or a write and comes from user or supervisor mode. If a check fails, the walk stops with a fault and a cause code, and no later read is issued. The walker takes one request at a time. It has a single-beat read port toward memory, and a response may arrive any number of cycles after its request.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After reset, `req_ready` is 1 and `mem_req` and `done_valid` are 0.
- R2: When `paging_en` is 0 at acceptance, `done_valid` rises in the next cycle with `done_fault`=0, `done_cause`=0 and `done_paddr` equal to the linear address, and no memory read is issued.
- R3: When `paging_en` is 1 at acceptance, `mem_req` is high for exactly one cycle, starting the cycle after acceptance. The address is {root_base[31:12], vaddr[31:22], 2'b00}.
- R4: When a directory entry passes its checks, a one-cycle table read follows in the cycle after the response. The address is {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R5: When a table entry passes its checks, `done_valid` rises in the cycle after that response, with `done_paddr` = {tbl_entry[31:12], vaddr[11:0]} and `done_cause`=0.
- R6: Entry bit 0 is the present bit. An absent directory entry faults with cause 1 and no table read. An absent table entry faults with cause 2.
- R7: An access with `req_user`=1 to an entry whose bit 2 (user) is 0, at either level, faults with cause 4.
- R8: A write (`req_write`=1) to an entry whose bit 1 (writable) is 0, at either level, faults with cause 3. At one level the priority is absent, then user, then write.
- R9: `done_valid` is a one-cycle pulse, and `req_ready` is high again in the cycle after it. A fault reports `done_fault`=1 with `done_paddr`=0. The fault pulse comes in the cycle after the failing response.
- R10: Changes on `req_valid` and `req_vaddr` during a walk have no effect. The walk in progress issues only its own reads and returns the result of the address it accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | 1: walk the tables; 0: pass the address through |
| root_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | Result is a page fault |
| done_cause | output | 3 | 0 none, 1 directory absent, 2 table absent, 3 write to read-only, 4 user to supervisor |
| done_paddr | output | 32 | Physical address (0 on a fault) |

## Verification
The bench counts falling edges from the acceptance edge to the one where `done_valid` is first seen high. It then checks that count exactly against the value it expects for each case. With the bench's read latency of L cycles, a bypass is due at count 0 and a directory fault at L+1. A table fault or a full translation is due at 2(L+1), because each level costs the registered request, L cycles of memory and the registered decision. The bench samples `mem_req` on every falling edge to count reads and record their addresses. It checks at the falling edge after the pulse that `done_valid` has dropped and `req_ready` is back.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_DIR_ABSENT = 3'd1,
    CAUSE_TBL_ABSENT = 3'd2,
    CAUSE_WRITE_RO   = 3'd3,
    CAUSE_USER_SUP   = 3'd4
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_READ_TBL,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int PERM_W     = 3;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;

endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
  parameter int IDX_W = 10,
  localparam int OFF_W  = IDX_W + 2,
  localparam int ADDR_W = 2 * IDX_W + OFF_W
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [IDX_W-1:0]  dir_idx,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [OFF_W-1:0]  pg_off
);
  // Top field picks the directory slot, middle the table slot.
  assign dir_idx = vaddr[ADDR_W-1 -: IDX_W];
  assign tbl_idx = vaddr[OFF_W +: IDX_W];
  assign pg_off  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [PERM_W-1:0] perm_bits,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              tbl_level,
  output logic              fault,
  output fault_cause_e      cause
);
  // Priority inside one level: absent, then user/supervisor, then write.
  always_comb begin
    fault = 1'b1;
    if (!perm_bits[BIT_PRESENT])
      cause = tbl_level ? CAUSE_TBL_ABSENT : CAUSE_DIR_ABSENT;
    else if (is_user && !perm_bits[BIT_USER])
      cause = CAUSE_USER_SUP;
    else if (is_write && !perm_bits[BIT_WRITE])
      cause = CAUSE_WRITE_RO;
    else begin
      cause = CAUSE_NONE;
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int OFF_W  = IDX_W + 2,
  localparam int ADDR_W = 2 * IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paging_en,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic [2:0]        done_cause,
  output logic [ADDR_W-1:0] done_paddr
);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam logic [1:0] ENT_PAD = 2'b00;

  walk_state_e       state;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q, usr_q;

  logic [ADDR_W-1:0] split_va;
  logic [IDX_W-1:0]  dir_idx, tbl_idx;
  logic [OFF_W-1:0]  pg_off;
  logic              chk_fault;
  fault_cause_e      chk_cause;
  logic [BASE_W-1:0] ent_base;
  logic              unused_bits;

  assign req_ready   = (state == ST_IDLE);
  assign split_va    = req_ready ? req_vaddr : va_q;
  assign ent_base    = mem_rsp_data[ADDR_W-1:OFF_W];
  assign unused_bits = ^{mem_rsp_data[OFF_W-1:PERM_W], root_base[OFF_W-1:0]};

  ptw_addr_split #(.IDX_W(IDX_W)) u_split (
    .vaddr   (split_va),
    .dir_idx (dir_idx),
    .tbl_idx (tbl_idx),
    .pg_off  (pg_off)
  );

  ptw_perm_check u_perm (
    .perm_bits (mem_rsp_data[PERM_W-1:0]),
    .is_write  (wr_q),
    .is_user   (usr_q),
    .tbl_level (state == ST_READ_TBL),
    .fault     (chk_fault),
    .cause     (chk_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done_valid <= 1'b0;
      done_fault <= 1'b0;
      done_cause <= CAUSE_NONE;
      done_paddr <= '0;
    end else begin
      mem_req    <= 1'b0;
      done_valid <= 1'b0;
      done_fault <= 1'b0;
      done_cause <= CAUSE_NONE;
      done_paddr <= '0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          if (!paging_en) begin
            state      <= ST_DONE;
            done_valid <= 1'b1;
            done_paddr <= req_vaddr;
          end else begin
            state    <= ST_READ_DIR;
            mem_req  <= 1'b1;
            mem_addr <= {root_base[ADDR_W-1:OFF_W], dir_idx, ENT_PAD};
          end
        end
        ST_READ_DIR, ST_READ_TBL: if (mem_rsp_valid) begin
          if (chk_fault) begin
            state      <= ST_FAULT;
            done_valid <= 1'b1;
            done_fault <= 1'b1;
            done_cause <= chk_cause;
          end else if (state == ST_READ_DIR) begin
            state    <= ST_READ_TBL;
            mem_req  <= 1'b1;
            mem_addr <= {ent_base, tbl_idx, ENT_PAD};
          end else begin
            state      <= ST_DONE;
            done_valid <= 1'b1;
            done_paddr <= {ent_base, pg_off};
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int IDX_W = 10,
  localparam int OFF_W  = IDX_W + 2,
  localparam int ADDR_W = 2 * IDX_W + OFF_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    paging_en,
  input logic [ADDR_W-1:OFF_W]   root_hi,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_vaddr,
  input logic                    mem_req,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    done_valid,
  input logic                    done_fault,
  input logic [2:0]              done_cause,
  input logic [ADDR_W-1:0]       done_paddr
);
  a_r1_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  a_r2_bypass_result: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=>
      (done_valid && !done_fault && !mem_req && done_paddr == $past(req_vaddr)));

  a_r3_dir_read_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_en) |=>
      (mem_req && mem_addr == {$past(root_hi), $past(req_vaddr[ADDR_W-1 -: IDX_W]), 2'b00}));

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (!done_valid && req_ready));

  a_r9_fault_shape: assert property (@(posedge clk) disable iff (rst)
    done_fault |-> (done_valid && done_paddr == '0 && done_cause != 3'd0));

  a_r5_ok_cause: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault) |-> (done_cause == 3'd0));
endmodule

bind ptw_walker ptw_walker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .paging_en  (paging_en),
  .root_hi    (root_base[ADDR_W-1:OFF_W]),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .done_valid (done_valid),
  .done_fault (done_fault),
  .done_cause (done_cause),
  .done_paddr (done_paddr)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  localparam int LAT = 2;
  localparam logic [31:0] ROOT = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic paging_en = 1'b0;
  logic [31:0] root_base = ROOT;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, mem_req, done_valid, done_fault;
  logic [31:0] mem_addr, done_paddr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [2:0] done_cause;

  int n_tests = 0, n_fail = 0, n_reads = 0;
  logic [31:0] alog [2];
  logic [31:0] pmem [logic [31:0]];
  bit finished = 0;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst(rst), .paging_en(paging_en), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault),
    .done_cause(done_cause), .done_paddr(done_paddr)
  );

  // Memory model: answers each read LAT falling edges after seeing it.
  initial begin
    int cnt;
    logic [31:0] a;
    cnt = 0; a = '0;
    forever begin
      @(negedge clk);
      if (cnt == 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pmem.exists(a) ? pmem[a] : 32'h0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (cnt > 0) cnt--;
      if (mem_req) begin
        if (n_reads < 2) alog[n_reads] = mem_addr;
        n_reads++;
        a = mem_addr;
        cnt = LAT;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] dir_addr(logic [31:0] va);
    return {ROOT[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] tbl_addr(logic [31:0] dent, logic [31:0] va);
    return {dent[31:12], va[21:12], 2'b00};
  endfunction

  task automatic xlate(string req, logic [31:0] va, bit wr, bit usr, bit pg, bit hold,
                       bit exp_fault, logic [2:0] exp_cause, logic [31:0] exp_pa,
                       int exp_reads, int exp_lat, logic [31:0] exp_a1);
    int lat;
    @(negedge clk);
    check("R1", "ready before request", {31'b0, req_ready}, 32'd1);
    req_vaddr = va; req_write = wr; req_user = usr; paging_en = pg;
    req_valid = 1'b1; n_reads = 0;
    @(negedge clk);
    if (hold) req_vaddr = ~va; else req_valid = 1'b0;
    lat = 0;
    while (!done_valid && lat < 50) begin @(negedge clk); lat++; end
    req_valid = 1'b0;
    check(req, "latency", lat, exp_lat);
    check(req, "fault", {31'b0, done_fault}, {31'b0, exp_fault});
    check(req, "cause", {29'b0, done_cause}, {29'b0, exp_cause});
    check(req, "paddr", done_paddr, exp_pa);
    check(req, "read count", n_reads, exp_reads);
    if (exp_reads > 0) check("R3", "directory read address", alog[0], dir_addr(va));
    if (exp_reads > 1) check("R4", "table read address", alog[1], exp_a1);
    @(negedge clk);
    check("R9", "done pulse ends", {31'b0, done_valid}, 32'd0);
    check("R9", "ready after result", {31'b0, req_ready}, 32'd1);
  endtask

  localparam int LW = 2 * (LAT + 1);
  localparam int LD = LAT + 1;

  task automatic t_reset();
    check("R1", "reset ready", {31'b0, req_ready}, 32'd1);
    check("R1", "reset mem_req", {31'b0, mem_req}, 32'd0);
    check("R1", "reset done_valid", {31'b0, done_valid}, 32'd0);
  endtask

  task automatic t_bypass();
    xlate("R2", 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'hDEAD_BEEF, 0, 0, 32'h0);
    xlate("R2", 32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_0FFF, 0, 0, 32'h0);
  endtask

  task automatic t_walk_ok();
    xlate("R5", 32'h1234_5678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'hABCD_E678, 2, LW,
          tbl_addr(32'h0020_0007, 32'h1234_5678));
    xlate("R5", 32'h0040_1ABC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h1234_5ABC, 2, LW,
          tbl_addr(32'h0030_0003, 32'h0040_1ABC));
  endtask

  task automatic t_absent();
    xlate("R6", 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 32'h0, 1, LD, 32'h0);
    xlate("R6", 32'h0040_2000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 32'h0, 2, LW,
          tbl_addr(32'h0030_0003, 32'h0040_2000));
  endtask

  task automatic t_user_sup();
    xlate("R7", 32'h0040_1ABC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0, 1, LD, 32'h0);
    xlate("R7", 32'h1234_7000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0, 2, LW,
          tbl_addr(32'h0020_0007, 32'h1234_7000));
  endtask

  task automatic t_write_ro();
    xlate("R8", 32'h1234_6000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 32'h0, 2, LW,
          tbl_addr(32'h0020_0007, 32'h1234_6000));
    xlate("R8", 32'h1234_6044, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h5555_5044, 2, LW,
          tbl_addr(32'h0020_0007, 32'h1234_6044));
    xlate("R8", 32'h00C0_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0, 1, LD, 32'h0);
  endtask

  task automatic t_busy_hold();
    xlate("R10", 32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 32'hABCD_E678, 2, LW,
          tbl_addr(32'h0020_0007, 32'h1234_5678));
  endtask

  initial begin
    pmem[32'h0010_0120] = 32'h0020_0007;  // dir 0x048: P W U
    pmem[32'h0020_0D14] = 32'hABCD_E007;  // tbl 0x345: P W U
    pmem[32'h0020_0D18] = 32'h5555_5005;  // tbl 0x346: P U, read-only
    pmem[32'h0020_0D1C] = 32'h6666_6003;  // tbl 0x347: P W, supervisor
    pmem[32'h0010_0004] = 32'h0030_0003;  // dir 0x001: P W, supervisor
    pmem[32'h0030_0004] = 32'h1234_5003;  // tbl 0x001
    pmem[32'h0030_0008] = 32'h0000_0006;  // tbl 0x002: absent
    pmem[32'h0010_000C] = 32'h0040_0001;  // dir 0x003: P only
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_bypass();
    t_walk_ok();
    t_absent();
    t_user_sup();
    t_write_ro();
    t_busy_hold();
    t_bypass();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule